// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is the control front end of a single-port synchronous SRAM. The SRAM has a 32-bit data path split into four byte lanes. On every rising clock edge it samples three chip enables, two address strobes and the write controls. From these it decides whether the edge starts a read, starts a write, completes a write or does nothing. It captures the address and produces per-lane write enables for a behavioural word array of 1024 entries. It also computes the drive-enable for the shared data bus, which is exposed here as a separate input bus, output bus and drive flag.

There are two address strobes. The processor-side strobe (`proc_strobe_n`) wins over the controller-side strobe (`ctrl_strobe_n`). On the edge where the processor-side strobe starts an access, the write controls are not looked at. The write controls are sampled on the next edge instead. The controller-side strobe decides read or write on its own start edge.

The access sequencer has three states:
- `ST_IDLE`: no access is open.
- `ST_PROC_OPEN`: a processor-side access was started on the previous edge. Its read data is on offer and its write window is open.
- `ST_READ_OUT`: a controller-side read was started on the previous edge and its data is on offer.

The transitions are:
- Any state goes to `ST_PROC_OPEN` on a processor-side start.
- Any state goes to `ST_READ_OUT` on a controller-side start with no write detected.
- `ST_PROC_OPEN` goes to `ST_IDLE` when a write is detected; this is the write-completion edge.
- Every other edge, including a controller-side write, goes to `ST_IDLE`.

Top module: `sram_burst_ctrl`

## Requirements
- R1: An access starts only on an edge where `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. On any other edge outside the write window of R3, the array is not written, the address is not captured and the state becomes `ST_IDLE`.
- R2: If `proc_strobe_n`=0 on a start edge, the address is captured and a read of that word is launched. The write controls on that same edge are ignored. The word read appears on `data_out` during the next cycle.
- R3: On the edge after a processor-side start, a detected write stores `data_in` into the captured address, masked by lane. On that edge the strobes and `addr` are ignored, and the state returns to `ST_IDLE`. If no write is detected on that edge, it is treated like an edge in `ST_IDLE`.
- R4: A start edge with `ctrl_strobe_n`=0, `proc_strobe_n`=1 and a write detected stores `data_in` into `addr` on that edge.
- R5: `ctrl_strobe_n` has no effect on any edge where `proc_strobe_n`=0; the processor-side rule applies.
- R6: `proc_strobe_n`=0 has no effect while `ce_a_n`=1, whatever the other enables and strobes do.
- R7: A write is detected when `gwr_n`=0, or when `bwr_en_n`=0 and at least one bit of `lane_wr_n` is 0. All write controls are active low.
- R8: With `gwr_n`=0 all four lanes are written. Otherwise `lane_wr_n[k]`=0 writes `data_in[8k+7:8k]`: bit 0 is bits 7:0, bit 1 is 15:8, bit 2 is 23:16 and bit 3 is 31:24. Unselected lanes keep their old contents.
- R9: `data_oe` is 0 in any cycle where a write is detected on the inputs, whatever `oe_n` is, including partial-lane writes.
- R10: A start edge with `ctrl_strobe_n`=0, `proc_strobe_n`=1 and no write detected launches a read of `addr`. The word appears on `data_out` during the next cycle.
- R11: `data_oe` is 1 only while `oe_n`=0 in a cycle that follows a read launch, that is, in `ST_PROC_OPEN` or `ST_READ_OUT`.
- R12: After reset the state is `ST_IDLE` and `data_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_a_n | input | 1 | Chip enable A, active low; also gates the processor-side strobe |
| ce_b | input | 1 | Chip enable B, active high |
| ce_c_n | input | 1 | Chip enable C, active low |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low, higher priority |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low |
| addr | input | ADDR_W (10) | Word address |
| gwr_n | input | 1 | Global write, all lanes, active low |
| bwr_en_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | LANES (4) | Per-lane write strobes, active low |
| oe_n | input | 1 | Output enable, active low |
| data_in | input | 32 | Write data from the shared bus |
| data_out | output | 32 | Read data toward the shared bus |
| data_oe | output | 1 | Bus drive enable for `data_out` |

## Verification
The properties assume that `rst_n` is low long enough to clear the sequencer. They also assume that every input is stable around the rising edge. The write controls are only taken as meaningful while `rst_n` is high. The bench drives all inputs shortly after each rising edge and keeps them constant through the next edge. Random stimulus keeps addresses inside a small window so that reads hit words already written, and the reference model compares only the bytes it has seen written. Directed sequences cover these cases:
- conflicting strobes,
- disabled enables,
- writes with a zero lane mask,
- writes asserted while a read is on offer.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_PROC_OPEN = 2'd1,
        ST_READ_OUT  = 2'd2
    } acc_state_t;

    // Active-low lane strobes to an active-high write mask.
    function automatic logic [3:0] lanes_from_strobes(
        input logic       gwr_n,
        input logic       bwr_en_n,
        input logic [3:0] strobes_n
    );
        if (!gwr_n)
            return 4'hF;
        else if (!bwr_en_n)
            return ~strobes_n;
        else
            return 4'h0;
    endfunction

endpackage

// File: rtl/strobe_decode.sv
module strobe_decode #(
    parameter int LANES = 4
) (
    input  logic             ce_a_n,
    input  logic             ce_b,
    input  logic             ce_c_n,
    input  logic             proc_strobe_n,
    input  logic             ctrl_strobe_n,
    input  logic             gwr_n,
    input  logic             bwr_en_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic             proc_go,
    output logic             ctrl_go,
    output logic             wr_seen,
    output logic [LANES-1:0] lane_mask
);

    logic chip_sel;
    logic any_lane;

    always_comb begin
        chip_sel = !ce_a_n && ce_b && !ce_c_n;
        // processor-side strobe wins; it needs every enable
        proc_go  = chip_sel && !proc_strobe_n;
        ctrl_go  = chip_sel && proc_strobe_n && !ctrl_strobe_n;
        any_lane = |(~lane_wr_n);
        wr_seen  = !gwr_n || (!bwr_en_n && any_lane);
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            always_comb begin
                if (!gwr_n)
                    lane_mask[g] = 1'b1;
                else
                    lane_mask[g] = !bwr_en_n && !lane_wr_n[g];
            end
        end
    endgenerate

endmodule

// File: rtl/access_fsm.sv
module access_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_go,
    input  logic              ctrl_go,
    input  logic              wr_seen,
    input  logic [LANES-1:0]  lane_mask,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              oe_n,
    output acc_state_t        state_o,
    output logic [LANES-1:0]  mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              bus_drive
);

    acc_state_t        state_q, state_d;
    logic [ADDR_W-1:0] cap_q;
    logic              finishing;
    logic              accept;

    // The edge that closes a processor-side write owns the cycle.
    always_comb begin
        finishing = (state_q == ST_PROC_OPEN) && wr_seen;
        accept    = !finishing;
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_PROC_OPEN: begin
                if (wr_seen)
                    state_d = ST_IDLE;
                else if (proc_go)
                    state_d = ST_PROC_OPEN;
                else if (ctrl_go)
                    state_d = ST_READ_OUT;
                else
                    state_d = ST_IDLE;
            end
            ST_IDLE, ST_READ_OUT: begin
                if (proc_go)
                    state_d = ST_PROC_OPEN;
                else if (ctrl_go && !wr_seen)
                    state_d = ST_READ_OUT;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept && (proc_go || ctrl_go))
                cap_q <= addr_in;
        end
    end

    always_comb begin
        mem_we    = '0;
        mem_waddr = addr_in;
        mem_re    = 1'b0;
        mem_raddr = addr_in;
        bus_drive = 1'b0;
        unique case (state_q)
            ST_PROC_OPEN: begin
                mem_waddr = cap_q;
                if (wr_seen)
                    mem_we = lane_mask;
                else
                    mem_re = proc_go || ctrl_go;
                bus_drive = !oe_n && !wr_seen;
            end
            ST_READ_OUT: begin
                if (ctrl_go && wr_seen)
                    mem_we = lane_mask;
                mem_re    = proc_go || (ctrl_go && !wr_seen);
                bus_drive = !oe_n && !wr_seen;
            end
            ST_IDLE: begin
                if (ctrl_go && wr_seen)
                    mem_we = lane_mask;
                mem_re = proc_go || (ctrl_go && !wr_seen);
            end
            default: begin
                mem_we = '0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/lane_array.sv
module lane_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    re,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_bank
            logic [LANE_W-1:0] bank [DEPTH];
            logic [LANE_W-1:0] rd_q;

            always_ff @(posedge clk) begin
                if (we[l])
                    bank[waddr] <= wdata[l*LANE_W +: LANE_W];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    rd_q <= '0;
                else if (re)
                    rd_q <= bank[raddr];
            end

            assign rdata[l*LANE_W +: LANE_W] = rd_q;
        end
    endgenerate

endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce_a_n,
    input  logic                    ce_b,
    input  logic                    ce_c_n,
    input  logic                    proc_strobe_n,
    input  logic                    ctrl_strobe_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    gwr_n,
    input  logic                    bwr_en_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] data_in,
    output logic [LANES*LANE_W-1:0] data_out,
    output logic                    data_oe
);

    logic              proc_go;
    logic              ctrl_go;
    logic              wr_seen;
    logic [LANES-1:0]  lane_mask;
    acc_state_t        fsm_state;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] waddr;
    logic              rd_launch;
    logic [ADDR_W-1:0] raddr;

    strobe_decode #(
        .LANES(LANES)
    ) u_decode (
        .ce_a_n        (ce_a_n),
        .ce_b          (ce_b),
        .ce_c_n        (ce_c_n),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .gwr_n         (gwr_n),
        .bwr_en_n      (bwr_en_n),
        .lane_wr_n     (lane_wr_n),
        .proc_go       (proc_go),
        .ctrl_go       (ctrl_go),
        .wr_seen       (wr_seen),
        .lane_mask     (lane_mask)
    );

    access_fsm #(
        .ADDR_W(ADDR_W),
        .LANES (LANES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .proc_go   (proc_go),
        .ctrl_go   (ctrl_go),
        .wr_seen   (wr_seen),
        .lane_mask (lane_mask),
        .addr_in   (addr),
        .oe_n      (oe_n),
        .state_o   (fsm_state),
        .mem_we    (lane_we),
        .mem_waddr (waddr),
        .mem_re    (rd_launch),
        .mem_raddr (raddr),
        .bus_drive (data_oe)
    );

    lane_array #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lane_we),
        .waddr (waddr),
        .wdata (data_in),
        .re    (rd_launch),
        .raddr (raddr),
        .rdata (data_out)
    );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker
    import sram_ctrl_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_a_n,
    input logic             ce_b,
    input logic             ce_c_n,
    input logic             proc_strobe_n,
    input logic             gwr_n,
    input logic             bwr_en_n,
    input logic [LANES-1:0] lane_wr_n,
    input logic             oe_n,
    input logic             data_oe,
    input acc_state_t       fsm_state,
    input logic [LANES-1:0] lane_we
);

    logic enabled;
    logic wr_in;
    assign enabled = !ce_a_n && ce_b && !ce_c_n;
    assign wr_in   = !gwr_n || (!bwr_en_n && (lane_wr_n != '1));

    assert_ce_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != ST_PROC_OPEN && !enabled) |-> (lane_we == '0));

    assert_ce_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != ST_PROC_OPEN && !enabled) |=> (fsm_state == ST_IDLE));

    assert_proc_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != ST_PROC_OPEN && !proc_strobe_n) |-> (lane_we == '0));

    assert_proc_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_PROC_OPEN && !gwr_n) |-> (lane_we == '1));

    assert_proc_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_PROC_OPEN && wr_in) |=> (fsm_state == ST_IDLE));

    assert_proc_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != ST_PROC_OPEN && enabled && !proc_strobe_n)
        |=> (fsm_state == ST_PROC_OPEN));

    assert_lane_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gwr_n && lane_we != '0) |-> ((lane_we & lane_wr_n) == '0));

    assert_tristate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_in |-> !data_oe);

    assert_oe_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || fsm_state == ST_IDLE) |-> !data_oe);

endmodule

bind sram_burst_ctrl sram_ctrl_checker #(.LANES(LANES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ce_a_n        (ce_a_n),
    .ce_b          (ce_b),
    .ce_c_n        (ce_c_n),
    .proc_strobe_n (proc_strobe_n),
    .gwr_n         (gwr_n),
    .bwr_en_n      (bwr_en_n),
    .lane_wr_n     (lane_wr_n),
    .oe_n          (oe_n),
    .data_oe       (data_oe),
    .fsm_state     (fsm_state),
    .lane_we       (lane_we)
);

// File: tb/tb_sram_burst_ctrl.sv
module tb_sram_burst_ctrl;

    localparam int AW = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
    logic        proc_strobe_n = 1'b1, ctrl_strobe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic        gwr_n = 1'b1, bwr_en_n = 1'b1;
    logic [3:0]  lane_wr_n = 4'hF;
    logic        oe_n = 1'b1;
    logic [31:0] data_in = '0;
    logic [31:0] data_out;
    logic        data_oe;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R12";
    bit    done = 1'b0;

    // reference model state
    int          m_state = 0;      // 0 idle, 1 processor open, 2 controller read
    int          m_addr  = 0;
    logic [31:0] m_rd    = '0;
    logic [3:0]  m_rdk   = '0;
    logic [31:0] m_mem   [int];
    logic [3:0]  m_known [int];

    always #2.5 clk = ~clk;

    sram_burst_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n), .addr(addr),
        .gwr_n(gwr_n), .bwr_en_n(bwr_en_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
    );

    function automatic bit wr_now();
        return !gwr_n || (!bwr_en_n && lane_wr_n != 4'hF);
    endfunction

    function automatic logic [3:0] wmask();
        if (!gwr_n) return 4'hF;
        if (!bwr_en_n) return ~lane_wr_n;
        return 4'h0;
    endfunction

    task automatic model_write(input int a, input logic [3:0] m);
        logic [31:0] w;
        logic [3:0]  k;
        w = m_mem.exists(a) ? m_mem[a] : 32'h0;
        k = m_known.exists(a) ? m_known[a] : 4'h0;
        for (int b = 0; b < 4; b++)
            if (m[b]) begin
                w[b*8 +: 8] = data_in[b*8 +: 8];
                k[b] = 1'b1;
            end
        m_mem[a] = w;
        m_known[a] = k;
    endtask

    task automatic model_read(input int a);
        m_rd  = m_mem.exists(a) ? m_mem[a] : 32'h0;
        m_rdk = m_known.exists(a) ? m_known[a] : 4'h0;
    endtask

    // reference update at each rising edge (inputs are stable here)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0;
        end else begin
            bit ok;
            ok = !ce_a_n && ce_b && !ce_c_n;
            if (m_state == 1 && wr_now()) begin
                model_write(m_addr, wmask());
                m_state = 0;
            end else if (ok && !proc_strobe_n) begin
                m_addr = int'(addr);
                model_read(m_addr);
                m_state = 1;
            end else if (ok && !ctrl_strobe_n) begin
                m_addr = int'(addr);
                if (wr_now()) begin
                    model_write(m_addr, wmask());
                    m_state = 0;
                end else begin
                    model_read(m_addr);
                    m_state = 2;
                end
            end else begin
                m_state = 0;
            end
        end
    end

    // compare at every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_oe;
            logic [31:0] km;
            exp_oe = (m_state != 0) && !oe_n && !wr_now();
            n_vec++;
            if (data_oe !== exp_oe) begin
                n_bad++;
                $display("FAIL %s: data_oe actual %b expected %b at %0t",
                         cur_req, data_oe, exp_oe, $time);
            end else if (exp_oe) begin
                for (int b = 0; b < 4; b++) km[b*8 +: 8] = {8{m_rdk[b]}};
                if ((data_out & km) !== (m_rd & km)) begin
                    n_bad++;
                    $display("FAIL %s: data_out actual %h expected %h (mask %h)",
                             cur_req, data_out, m_rd, km);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
        proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1;
        gwr_n = 1'b1; bwr_en_n = 1'b1; lane_wr_n = 4'hF; oe_n = 1'b0;
    endtask

    task automatic ctrl_write(input int a, input logic [31:0] d);
        quiet(); ctrl_strobe_n = 1'b0; gwr_n = 1'b0; oe_n = 1'b1;
        addr = AW'(a); data_in = d;
        tick();
        quiet();
    endtask

    task automatic ctrl_read(input int a);
        quiet(); ctrl_strobe_n = 1'b0; addr = AW'(a);
        tick();
        quiet();
        tick();
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R12: reset state
        repeat (3) @(posedge clk);
        #1;
        n_vec++;
        if (data_oe !== 1'b0) begin
            n_bad++;
            $display("FAIL R12: data_oe actual %b expected 0 in reset", data_oe);
        end
        rst_n = 1'b1;
        quiet();
        tick();

        // R4: controller-side full writes
        cur_req = "R4";
        ctrl_write(5, 32'hA1B2C3D4);
        ctrl_write(6, 32'h11223344);
        ctrl_write(20, 32'hFFEEDDCC);
        ctrl_write(30, 32'h0BADF00D);

        // R10: controller-side read, data next cycle
        cur_req = "R10";
        ctrl_read(5);
        ctrl_read(6);

        // R11: read with oe_n high must not drive
        cur_req = "R11";
        quiet(); ctrl_strobe_n = 1'b0; addr = 10'd5; oe_n = 1'b1;
        tick(); quiet(); oe_n = 1'b1; tick(); quiet();

        // R2/R3/R8: processor-side start ignores writes, next edge writes lanes 0 and 2
        cur_req = "R2";
        quiet(); proc_strobe_n = 1'b0; addr = 10'd20; gwr_n = 1'b0; data_in = 32'h99999999;
        tick();
        cur_req = "R3";
        quiet(); bwr_en_n = 1'b0; lane_wr_n = 4'b1010; data_in = 32'h12345678;
        addr = 10'd6; ctrl_strobe_n = 1'b0;
        tick();
        quiet();
        cur_req = "R8";
        ctrl_read(20);

        // R7: byte-write enable low with no lane selected is a read
        cur_req = "R7";
        quiet(); ctrl_strobe_n = 1'b0; bwr_en_n = 1'b0; lane_wr_n = 4'hF;
        addr = 10'd6; data_in = 32'h0;
        tick(); quiet(); tick();
        // lanes low but byte-write enable high: also no write
        quiet(); ctrl_strobe_n = 1'b0; lane_wr_n = 4'h0; addr = 10'd6;
        tick(); quiet(); tick();

        // R5: both strobes with write: processor side wins, no write on that edge
        cur_req = "R5";
        quiet(); proc_strobe_n = 1'b0; ctrl_strobe_n = 1'b0; gwr_n = 1'b0;
        addr = 10'd30; data_in = 32'hDEADBEEF;
        tick(); quiet(); tick();
        ctrl_read(30);

        // R6 / R1: enables off
        cur_req = "R6";
        quiet(); ce_a_n = 1'b1; proc_strobe_n = 1'b0; ctrl_strobe_n = 1'b0; addr = 10'd5;
        tick(); quiet(); tick();
        cur_req = "R1";
        quiet(); ce_b = 1'b0; ctrl_strobe_n = 1'b0; gwr_n = 1'b0; addr = 10'd5;
        data_in = 32'h55555555;
        tick();
        quiet(); ce_c_n = 1'b1; ctrl_strobe_n = 1'b0; gwr_n = 1'b0; addr = 10'd5;
        tick(); quiet();
        ctrl_read(5);

        // R9: write controls raised while a read is on offer
        cur_req = "R9";
        quiet(); ctrl_strobe_n = 1'b0; addr = 10'd6;
        tick();
        quiet(); ce_a_n = 1'b1; bwr_en_n = 1'b0; lane_wr_n = 4'b1101;
        tick(); quiet(); tick();

        // mixed random traffic over a small address window
        cur_req = "R3";
        for (int i = 0; i < 16; i++) ctrl_write(i, $urandom);
        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            ce_a_n = (r < 6); ce_b = !(r > 96); ce_c_n = 1'b0;
            proc_strobe_n = ($urandom_range(0, 3) != 0);
            ctrl_strobe_n = ($urandom_range(0, 2) != 0);
            gwr_n = ($urandom_range(0, 4) != 0);
            bwr_en_n = ($urandom_range(0, 2) != 0);
            lane_wr_n = 4'($urandom);
            oe_n = ($urandom_range(0, 4) == 0);
            addr = AW'($urandom_range(0, 15));
            data_in = $urandom;
            tick();
        end

        quiet(); tick(); tick();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule